// File: doc/BRIEF.md
# DMA Request Handshake Unit (Peripheral Side)

This block sits on the peripheral side of one DMA channel of an ISA-style bus. Local logic arms a block transfer with a start pulse. Whenever local logic reports a unit ready to move, the block raises the bus request and holds it until the controller's active-low acknowledge is sampled. While the acknowledge is active and the address-enable line shows that the controller owns the bus, the block serves the I/O strobes. On a read strobe it drives its local data onto the bus. On a write strobe it captures bus data. Address decode plays no part in this.

The controller marks the last transfer of a block with a terminal-count pulse. When the block sees it, it pulses `done_o`, returns to idle and raises no further requests until it is armed again. Without a terminal count, it asks for the next transfer as soon as local data is ready. The channel number is a parameter. Channel 0 is rejected at elaboration because its acknowledge serves memory refresh. All bus inputs are treated as synchronous to `clk_i`.

Top module: `dma_req_unit`

## Requirements
- R1: While rst_ni is low and in the cycle after its release, drq_o, done_o, rd_pop_o, wr_push_o and bus_oe_o are all 0.
- R2: drq_o rises only after a start_i pulse has armed the block: with avail_i high, drq_o is 1 from the second rising edge after the start_i edge. drq_o stays 0 while the block is unarmed, whatever avail_i does.
- R3: Once raised, drq_o stays 1 for as long as dack_ni is sampled high. drq_o becomes 0 at the edge that samples dack_ni low.
- R4: Once the acknowledge is granted, bus_oe_o is 1 and bus_data_o equals rd_data_i in any cycle where dack_ni is low, aen_i is high and ior_ni is low.
- R5: A qualified read strobe (ior_ni low with dack_ni low and aen_i high) that then returns high produces a rd_pop_o pulse one cycle long. The pulse comes right after the edge that samples ior_ni high again.
- R6: A qualified write strobe that returns high produces a wr_push_o pulse one cycle long. At that pulse, wr_data_o holds bus_data_i as sampled in the last cycle iow_ni was low.
- R7: A strobe is ignored when dack_ni is high or aen_i is low. Such a strobe gives bus_oe_o 0 and causes no rd_pop_o or wr_push_o.
- R8: The block ends the block transfer when tc_i is seen high with dack_ni low during a granted transfer, either while the strobe is low or at its release. done_o then pulses for one cycle together with the completing pop or push, and drq_o stays 0 until the next start_i, even with avail_i high.
- R9: After a transfer completes without a terminal count, drq_o is 0 in the following cycle. drq_o rises again one edge later if avail_i is high, and otherwise at the first edge that samples avail_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus-synchronous clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Arms a block transfer (pulse) |
| avail_i | input | 1 | Local side has a unit ready to move |
| rd_data_i | input | DATA_W | Local data offered to read strobes |
| rd_pop_o | output | 1 | One read transfer completed |
| wr_data_o | output | DATA_W | Data captured from a write strobe |
| wr_push_o | output | 1 | One write transfer completed |
| done_o | output | 1 | Block ended by terminal count |
| drq_o | output | 1 | DMA request, active high |
| dack_ni | input | 1 | DMA acknowledge, active low |
| tc_i | input | 1 | Terminal-count pulse |
| aen_i | input | 1 | Controller owns the bus |
| ior_ni | input | 1 | I/O read strobe, active low |
| iow_ni | input | 1 | I/O write strobe, active low |
| bus_data_i | input | DATA_W | Data bus, inbound |
| bus_data_o | output | DATA_W | Data bus, outbound |
| bus_oe_o | output | 1 | Output enable for bus_data_o |

## Verification
The hardest cases to reach are the strobes that must have no effect. Examples are a read strobe while the request is still pending, and a strobe inside a granted cycle while address enable is low. Every observable result of such a strobe is a missing pulse. The bench therefore puts each ignored strobe just before a real transfer. The scoreboard must then see exactly one pop or push with the right data, and any extra pulse shows up as an unexpected item. The terminal count is given in both of its legal positions, during the strobe and at its release, and each time avail_i is left high to show that no new request follows.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_REQ   = 2'd2,
    ST_XFER  = 2'd3
  } hs_state_e;

  localparam int unsigned STB_RD = 0;
  localparam int unsigned STB_WR = 1;
  localparam int unsigned STB_N  = 2;
endpackage

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl
  import dma_hs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic avail_i,
  input  logic dack_ni,
  input  logic tc_i,
  input  logic xfer_done_i,
  output logic drq_o,
  output logic in_xfer_o,
  output logic done_o
);
  hs_state_e state_q, state_d;
  logic tc_seen_q, tc_now, tc_end, done_q;

  assign tc_now = tc_i & ~dack_ni;
  assign tc_end = tc_seen_q | tc_now;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i)     state_d = ST_ARMED;
      ST_ARMED: if (avail_i)     state_d = ST_REQ;
      ST_REQ:   if (!dack_ni)    state_d = ST_XFER;
      ST_XFER:  if (xfer_done_i) state_d = tc_end ? ST_IDLE : ST_ARMED;
      default:                   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      tc_seen_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == ST_XFER) & xfer_done_i & tc_end;
      if (state_q != ST_XFER || xfer_done_i) tc_seen_q <= 1'b0;
      else if (tc_now)                       tc_seen_q <= 1'b1;
    end
  end

  assign drq_o     = (state_q == ST_REQ);
  assign in_xfer_o = (state_q == ST_XFER);
  assign done_o    = done_q;
endmodule

// File: rtl/dma_hs_strobe.sv
module dma_hs_strobe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic qual_i,
  input  logic strobe_ni,
  output logic active_o,
  output logic release_o
);
  logic low_q;

  assign active_o  = qual_i & ~strobe_ni;
  // completion: qualified low phase last cycle, strobe high now
  assign release_o = low_q & strobe_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_q <= 1'b0;
    else         low_q <= active_o;
  end
endmodule

// File: rtl/dma_hs_wlatch.sv
module dma_hs_wlatch #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    data_o <= '0;
    else if (cap_i) data_o <= data_i;
  end
endmodule

// File: rtl/dma_req_unit.sv
module dma_req_unit
  import dma_hs_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CHANNEL = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              avail_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              rd_pop_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              wr_push_o,
  output logic              done_o,
  output logic              drq_o,
  input  logic              dack_ni,
  input  logic              tc_i,
  input  logic              aen_i,
  input  logic              ior_ni,
  input  logic              iow_ni,
  input  logic [DATA_W-1:0] bus_data_i,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_oe_o
);
  if (CHANNEL < 1 || CHANNEL > 7) begin : g_bad_channel
    $error("dma_req_unit: channel must be 1..7, channel 0 is refresh");
  end

  logic             in_xfer, qual, xfer_done;
  logic [STB_N-1:0] stb_n, stb_act, stb_rel;
  logic             pop_q, push_q;

  assign qual  = in_xfer & ~dack_ni & aen_i;
  assign stb_n = {iow_ni, ior_ni};

  for (genvar g = 0; g < STB_N; g++) begin : g_stb
    dma_hs_strobe u_stb (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .qual_i   (qual),
      .strobe_ni(stb_n[g]),
      .active_o (stb_act[g]),
      .release_o(stb_rel[g])
    );
  end

  assign xfer_done = |stb_rel;

  dma_hs_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .avail_i    (avail_i),
    .dack_ni    (dack_ni),
    .tc_i       (tc_i),
    .xfer_done_i(xfer_done),
    .drq_o      (drq_o),
    .in_xfer_o  (in_xfer),
    .done_o     (done_o)
  );

  dma_hs_wlatch #(.DATA_W(DATA_W)) u_wlatch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (stb_act[STB_WR]),
    .data_i(bus_data_i),
    .data_o(wr_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pop_q  <= 1'b0;
      push_q <= 1'b0;
    end else begin
      pop_q  <= stb_rel[STB_RD];
      push_q <= stb_rel[STB_WR];
    end
  end

  assign rd_pop_o   = pop_q;
  assign wr_push_o  = push_q;
  assign bus_oe_o   = stb_act[STB_RD];
  assign bus_data_o = rd_data_i;
endmodule

// File: rtl/dma_req_unit_chk.sv
module dma_req_unit_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic avail_i,
  input logic dack_ni,
  input logic drq_o,
  input logic done_o,
  input logic bus_oe_o,
  input logic rd_pop_o,
  input logic wr_push_o
);
  AST_DRQ_FROM_AVAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drq_o) |-> $past(avail_i)); // R2
  AST_DRQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drq_o && dack_ni |=> drq_o); // R3
  AST_DRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drq_o && !dack_ni |=> !drq_o); // R3
  AST_OE_NOT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> !drq_o && !dack_ni); // R4
  AST_POP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_pop_o |=> !rd_pop_o); // R5
  AST_PUSH_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_push_o |=> !wr_push_o); // R6
  AST_POP_PUSH_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_pop_o && wr_push_o)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_DONE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !drq_o && (rd_pop_o || wr_push_o)); // R8
  AST_DONE_STAYS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !drq_o); // R8
endmodule

bind dma_req_unit dma_req_unit_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .avail_i  (avail_i),
  .dack_ni  (dack_ni),
  .drq_o    (drq_o),
  .done_o   (done_o),
  .bus_oe_o (bus_oe_o),
  .rd_pop_o (rd_pop_o),
  .wr_push_o(wr_push_o)
);

// File: tb/tb_dma_req_unit.sv
module tb_dma_req_unit;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, avail = 0, dack_n = 1, tc = 0, aen = 0, ior_n = 1, iow_n = 1;
  logic [DW-1:0] rd_data = '0, bus_in = '0;
  logic [DW-1:0] wr_data, bus_out;
  logic rd_pop, wr_push, done, drq, bus_oe;

  always #10 clk = ~clk;

  dma_req_unit #(.DATA_W(DW), .CHANNEL(3)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .avail_i(avail),
    .rd_data_i(rd_data), .rd_pop_o(rd_pop), .wr_data_o(wr_data),
    .wr_push_o(wr_push), .done_o(done), .drq_o(drq), .dack_ni(dack_n),
    .tc_i(tc), .aen_i(aen), .ior_ni(ior_n), .iow_ni(iow_n),
    .bus_data_i(bus_in), .bus_data_o(bus_out), .bus_oe_o(bus_oe)
  );

  typedef struct { int kind; logic [DW-1:0] data; string req; } exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0;
  bit ended = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic expect_evt(input int kind, input logic [DW-1:0] d, input string req);
    exp_t e; e.kind = kind; e.data = d; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: 0 pop, 1 push, 2 done
  task automatic observe(input int kind, input logic [DW-1:0] d);
    exp_t e;
    if (exp_q.size() == 0) begin
      chk(0, "R7 unexpected event", kind, -1);
    end else begin
      e = exp_q.pop_front();
      chk(e.kind == kind && (kind != 1 || e.data == d), e.req,
          kind * 256 + int'(d), e.kind * 256 + int'(e.data));
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      if (rd_pop)  observe(0, '0);
      if (wr_push) observe(1, wr_data);
      if (done)    observe(2, '0);
    end
  end

  task automatic arm();
    start = 1; cyc(); start = 0;
  endtask

  task automatic rd_xfer(input logic [DW-1:0] d, input bit tc_low, input bit tc_rel);
    rd_data = d; aen = 1; ior_n = 0; tc = tc_low;
    #1;
    chk(bus_oe == 1'b1, "R4 oe", bus_oe, 1);
    chk(bus_out == d, "R4 data", bus_out, d);
    cyc();
    expect_evt(0, '0, "R5 pop");
    if (tc_low || tc_rel) expect_evt(2, '0, "R8 done");
    ior_n = 1; tc = tc_rel;
    cyc();
    tc = 0; dack_n = 1; aen = 0;
  endtask

  task automatic wr_xfer(input logic [DW-1:0] d0, input logic [DW-1:0] d1, input bit tc_rel);
    aen = 1; iow_n = 0; bus_in = d0; cyc();
    bus_in = d1; cyc();
    expect_evt(1, d1, "R6 push");
    if (tc_rel) expect_evt(2, '0, "R8 done");
    iow_n = 1; bus_in = 8'hEE; tc = tc_rel;
    cyc();
    tc = 0; dack_n = 1; aen = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!drq && !done && !rd_pop && !wr_push && !bus_oe, "R1 in reset", drq, 0);
    rst_n = 1;
    #1;
    chk(!drq && !done && !rd_pop && !wr_push && !bus_oe, "R1 after release", drq, 0);

    // unarmed: avail ignored
    avail = 1; cyc(); cyc();
    chk(drq == 0, "R2 unarmed", drq, 0);
    arm();
    chk(drq == 0, "R2 armed cycle", drq, 0);
    cyc();
    chk(drq == 1, "R2 request", drq, 1);

    // read strobe while request pending: ignored
    aen = 1; ior_n = 0; #1;
    chk(bus_oe == 0, "R7 no dack oe", bus_oe, 0);
    cyc(); ior_n = 1; cyc(); aen = 0;
    chk(drq == 1, "R3 hold", drq, 1);
    cyc();
    chk(drq == 1, "R3 hold long", drq, 1);
    dack_n = 0; cyc();
    chk(drq == 0, "R3 drop", drq, 0);

    // granted but aen low: ignored
    ior_n = 0; #1;
    chk(bus_oe == 0, "R7 no aen oe", bus_oe, 0);
    cyc(); ior_n = 1; iow_n = 0; cyc(); iow_n = 1; cyc();

    rd_xfer(8'hA5, 0, 0);
    chk(drq == 0, "R9 gap", drq, 0);
    cyc();
    chk(drq == 1, "R9 re-request", drq, 1);

    dack_n = 0; cyc();
    avail = 0;
    wr_xfer(8'h3C, 8'hC3, 0);
    cyc(); cyc();
    chk(drq == 0, "R9 waits avail", drq, 0);
    avail = 1; cyc();
    chk(drq == 1, "R9 avail request", drq, 1);

    // terminal count during strobe
    dack_n = 0; cyc();
    rd_xfer(8'h5A, 1, 0);
    chk(drq == 0, "R8 drq after done", drq, 0);
    cyc(); cyc(); cyc();
    chk(drq == 0, "R8 stays idle", drq, 0);

    // second block, terminal count at release of a write
    arm(); cyc();
    chk(drq == 1, "R2 rearm", drq, 1);
    dack_n = 0; cyc();
    wr_xfer(8'h11, 8'h96, 1);
    cyc(); cyc(); cyc();
    chk(drq == 0, "R8 idle after write tc", drq, 0);

    repeat (4) cyc();
    chk(exp_q.size() == 0, "R5 R6 R8 all events seen", exp_q.size(), 0);
    finish_run();
  end
endmodule